// File: doc/BRIEF.md
# Dual-Channel Register Decoder with Mode Pointer

This block is the processor-facing register front end of a two-channel serial controller. A 4-bit address, a read strobe and a write strobe select one of sixteen locations. The same address reaches different things for a read and for a write. Per-channel locations sit at addresses 0–3 (channel A) and 8–11 (channel B). Shared locations sit at addresses 4–7 and 12–15. The block stores the control registers, steers status and receive data from the datapaths onto the read bus, and turns command-style locations into one-cycle strobes for the serial datapaths, the counter/timer and the output port.

Each channel has two mode registers behind one address. A per-channel pointer picks between them. Reset, or a reset-pointer code written to that channel's command location, aims the pointer at the first mode register. Any access to the mode address then moves it to the second one, where it stays. Read data is combinational while the read strobe is high and zero otherwise. Every strobe and register update takes effect at the clock edge that ends the access.

Top module: `dual_chan_regdec`

## Requirements
- R1: While rst_n is low and after its release, every stored register is zero, both pointers are at mode register 1 (ptr_at2 = 0), and every strobe is low.
- R2: A read or a write of a channel's mode address (0 for A, 8 for B) sets that channel's ptr_at2 to 1 at the end of the access, and ptr_at2 then stays 1 for all later accesses until a reset-pointer command or reset.
- R3: A write to the mode address stores wdata into mode register 1 if ptr_at2 was 0 before the access, or into mode register 2 if it was 1. A read of the mode address returns the register picked by the pointer before the access.
- R4: A write to a channel's command address (2 for A, 10 for B) whose bits [6:4] equal 3'b001 clears that channel's ptr_at2. Any other value in that field leaves the pointer unchanged.
- R5: An access to one channel's addresses changes no register, pointer or strobe of the other channel.
- R6: In a command write, bit 0 enables the receiver, bit 1 disables it, bit 2 enables the transmitter and bit 3 disables it. When both the enable and disable bits are set, disable wins. When neither is set, the enable state is held.
- R7: Reads return: 0/8 selected mode register, 1/9 channel status input, 3/11 channel receive holding input, 4 input-change input, 5 interrupt-status input, 6 counter value high byte, 7 counter value low byte, 13 input port zero-extended.
- R8: Writes store: 1/9 channel clock select, 4 auxiliary control, 5 interrupt mask, 6 preset high byte, 7 preset low byte, 13 output configuration.
- R9: A read of address 14 pulses ctr_start, and a read of address 15 pulses ctr_stop, for exactly the one cycle after the access. Both reads return zero.
- R10: A write of address 14 pulses op_set_stb, and a write of address 15 pulses op_clr_stb, for the one cycle after the access. op_mask takes the written byte at the same time.
- R11: A write of 3/11 pulses that channel's tx_load for one cycle and puts the byte on that channel's tx_data. A read of 3/11 pulses that channel's rx_pop for one cycle.
- R12: Reads of 2, 10 and 12 return zero and change nothing. A write of 12 changes no register, pointer or strobe.
- R13: A command write with a nonzero field in bits [6:4] pulses that channel's cmd_misc_stb for one cycle and loads the field into cmd_misc_code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when bus_rd is low |
| stat_in | input | 2x8 | Per-channel status from the datapaths |
| rxh_in | input | 2x8 | Per-channel receive holding data |
| ipcr_in | input | 8 | Input-change value |
| isr_in | input | 8 | Interrupt status value |
| ctr_val_in | input | 16 | Counter current value |
| inport_in | input | 7 | Input port pins |
| mode1_q | output | 2x8 | Mode register 1 per channel |
| mode2_q | output | 2x8 | Mode register 2 per channel |
| csel_q | output | 2x8 | Clock select per channel |
| ptr_at2 | output | 2 | Mode pointer per channel, 1 = mode register 2 |
| rx_en_q | output | 2 | Receiver enable per channel |
| tx_en_q | output | 2 | Transmitter enable per channel |
| cmd_misc_stb | output | 2 | Miscellaneous command strobe per channel |
| cmd_misc_code | output | 2x3 | Last nonzero miscellaneous command per channel |
| tx_load | output | 2 | Transmit holding load strobe per channel |
| tx_data | output | 2x8 | Transmit byte per channel |
| rx_pop | output | 2 | Receive holding read strobe per channel |
| aux_q | output | 8 | Auxiliary control register |
| imask_q | output | 8 | Interrupt mask register |
| preset_q | output | 16 | Counter preset |
| opcfg_q | output | 8 | Output port configuration |
| op_set_stb | output | 1 | Set-output-bits strobe |
| op_clr_stb | output | 1 | Clear-output-bits strobe |
| op_mask | output | 8 | Mask for the set/clear strobes |
| ctr_start | output | 1 | Counter start strobe |
| ctr_stop | output | 1 | Counter stop strobe |

## Verification
The assertions assume bus_rd and bus_wr are never high in the same cycle, so each cycle carries at most one access and at most one strobe fires. Under that assumption the pointer, the command strobes and the counter and output-port strobes can each be traced back to a single access. The bench issues every access as a single-cycle strobe with an idle gap after it, and it never raises both strobes at once. It holds the datapath inputs steady during each access and changes them only between accesses.

// File: rtl/dual_chan_regdec_pkg.sv
package dual_chan_regdec_pkg;

  localparam int NUM_CH = 2;

  // channel-local offsets (bus_addr[1:0] when bus_addr[2] == 0)
  localparam logic [1:0] OFS_MODE = 2'd0;
  localparam logic [1:0] OFS_CSEL = 2'd1;
  localparam logic [1:0] OFS_CMD  = 2'd2;
  localparam logic [1:0] OFS_HOLD = 2'd3;

  // shared addresses
  localparam logic [3:0] ADR_AUX   = 4'd4;
  localparam logic [3:0] ADR_IMASK = 4'd5;
  localparam logic [3:0] ADR_PREHI = 4'd6;
  localparam logic [3:0] ADR_PRELO = 4'd7;
  localparam logic [3:0] ADR_RSVD  = 4'd12;
  localparam logic [3:0] ADR_OPCFG = 4'd13;
  localparam logic [3:0] ADR_CMD_A = 4'd14;
  localparam logic [3:0] ADR_CMD_B = 4'd15;

  localparam logic [2:0] MISC_RST_PTR = 3'd1;

  function automatic logic is_chan_addr(input logic [3:0] a);
    return !a[2];
  endfunction

  function automatic logic [2:0] misc_field(input logic [7:0] w);
    return w[6:4];
  endfunction

  // next enable state: disable wins over enable, neither holds
  function automatic logic en_next(input logic cur, input logic on, input logic off);
    return off ? 1'b0 : (on ? 1'b1 : cur);
  endfunction

  function automatic logic is_rsvd_read(input logic [3:0] a);
    return (is_chan_addr(a) && a[1:0] == OFS_CMD) || a == ADR_RSVD
           || a == ADR_CMD_A || a == ADR_CMD_B;
  endfunction

endpackage

// File: rtl/dual_chan_regdec_chan.sv
module dual_chan_regdec_chan
  import dual_chan_regdec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CH_ID  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] mode1_o,
  output logic [DATA_W-1:0] mode2_o,
  output logic [DATA_W-1:0] mode_sel_o,
  output logic [DATA_W-1:0] csel_o,
  output logic              ptr_o,
  output logic              rx_en_o,
  output logic              tx_en_o,
  output logic              misc_stb_o,
  output logic [2:0]        misc_code_o,
  output logic              tx_load_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              rx_pop_o,
  output logic              ptr_adv_o,
  output logic              ptr_rst_o
);
  localparam logic MY_CH = 1'(CH_ID);

  logic       hit_ch;
  logic       mode_hit;
  logic       cmd_wr;
  logic [2:0] misc;

  assign hit_ch    = (bus_addr[3] == MY_CH) && is_chan_addr(bus_addr);
  assign mode_hit  = hit_ch && bus_addr[1:0] == OFS_MODE && (bus_rd || bus_wr);
  assign cmd_wr    = hit_ch && bus_addr[1:0] == OFS_CMD && bus_wr;
  assign misc      = misc_field(bus_wdata);
  assign ptr_adv_o = mode_hit && !ptr_o;
  assign ptr_rst_o = cmd_wr && misc == MISC_RST_PTR;
  assign mode_sel_o = ptr_o ? mode2_o : mode1_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_o       <= 1'b0;
      mode1_o     <= '0;
      mode2_o     <= '0;
      csel_o      <= '0;
      rx_en_o     <= 1'b0;
      tx_en_o     <= 1'b0;
      misc_stb_o  <= 1'b0;
      misc_code_o <= '0;
      tx_load_o   <= 1'b0;
      tx_data_o   <= '0;
      rx_pop_o    <= 1'b0;
    end else begin
      if (ptr_rst_o)     ptr_o <= 1'b0;
      else if (mode_hit) ptr_o <= 1'b1;

      if (mode_hit && bus_wr) begin
        if (ptr_o) mode2_o <= bus_wdata;
        else       mode1_o <= bus_wdata;
      end

      if (hit_ch && bus_addr[1:0] == OFS_CSEL && bus_wr) csel_o <= bus_wdata;

      if (cmd_wr) begin
        rx_en_o <= en_next(rx_en_o, bus_wdata[0], bus_wdata[1]);
        tx_en_o <= en_next(tx_en_o, bus_wdata[2], bus_wdata[3]);
        if (misc != 3'd0) misc_code_o <= misc;
      end
      misc_stb_o <= cmd_wr && misc != 3'd0;

      tx_load_o <= hit_ch && bus_addr[1:0] == OFS_HOLD && bus_wr;
      rx_pop_o  <= hit_ch && bus_addr[1:0] == OFS_HOLD && bus_rd;
      if (hit_ch && bus_addr[1:0] == OFS_HOLD && bus_wr) tx_data_o <= bus_wdata;
    end
  end
endmodule

// File: rtl/dual_chan_regdec_shared.sv
module dual_chan_regdec_shared
  import dual_chan_regdec_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CTR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] aux_o,
  output logic [DATA_W-1:0] imask_o,
  output logic [CTR_W-1:0]  preset_o,
  output logic [DATA_W-1:0] opcfg_o,
  output logic [DATA_W-1:0] op_mask_o,
  output logic              op_set_o,
  output logic              op_clr_o,
  output logic              ctr_start_o,
  output logic              ctr_stop_o
);
  logic wr_a, rd_a, cmd14, cmd15;
  assign wr_a  = bus_wr && !is_chan_addr(bus_addr);
  assign rd_a  = bus_rd && !is_chan_addr(bus_addr);
  assign cmd14 = bus_addr == ADR_CMD_A;
  assign cmd15 = bus_addr == ADR_CMD_B;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aux_o       <= '0;
      imask_o     <= '0;
      preset_o    <= '0;
      opcfg_o     <= '0;
      op_mask_o   <= '0;
      op_set_o    <= 1'b0;
      op_clr_o    <= 1'b0;
      ctr_start_o <= 1'b0;
      ctr_stop_o  <= 1'b0;
    end else begin
      if (wr_a && bus_addr == ADR_AUX)   aux_o   <= bus_wdata;
      if (wr_a && bus_addr == ADR_IMASK) imask_o <= bus_wdata;
      if (wr_a && bus_addr == ADR_PREHI) preset_o[CTR_W-1:DATA_W] <= bus_wdata;
      if (wr_a && bus_addr == ADR_PRELO) preset_o[DATA_W-1:0]     <= bus_wdata;
      if (wr_a && bus_addr == ADR_OPCFG) opcfg_o <= bus_wdata;
      if (wr_a && (cmd14 || cmd15))      op_mask_o <= bus_wdata;
      op_set_o    <= wr_a && cmd14;
      op_clr_o    <= wr_a && cmd15;
      ctr_start_o <= rd_a && cmd14;
      ctr_stop_o  <= rd_a && cmd15;
    end
  end
endmodule

// File: rtl/dual_chan_regdec_rmux.sv
module dual_chan_regdec_rmux
  import dual_chan_regdec_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CTR_W = 2 * DATA_W
) (
  input  logic [3:0]                    bus_addr,
  input  logic                          bus_rd,
  input  logic [NUM_CH-1:0][DATA_W-1:0] mode_sel,
  input  logic [NUM_CH-1:0][DATA_W-1:0] stat_in,
  input  logic [NUM_CH-1:0][DATA_W-1:0] rxh_in,
  input  logic [DATA_W-1:0]             ipcr_in,
  input  logic [DATA_W-1:0]             isr_in,
  input  logic [CTR_W-1:0]              ctr_val_in,
  input  logic [DATA_W-2:0]             inport_in,
  output logic [DATA_W-1:0]             rdata
);
  always_comb begin
    rdata = '0;
    if (bus_rd && !is_rsvd_read(bus_addr)) begin
      if (is_chan_addr(bus_addr)) begin
        case (bus_addr[1:0])
          OFS_MODE: rdata = mode_sel[bus_addr[3]];
          OFS_CSEL: rdata = stat_in[bus_addr[3]];
          OFS_HOLD: rdata = rxh_in[bus_addr[3]];
          default:  rdata = '0;
        endcase
      end else begin
        case (bus_addr)
          ADR_AUX:   rdata = ipcr_in;
          ADR_IMASK: rdata = isr_in;
          ADR_PREHI: rdata = ctr_val_in[CTR_W-1:DATA_W];
          ADR_PRELO: rdata = ctr_val_in[DATA_W-1:0];
          ADR_OPCFG: rdata = {1'b0, inport_in};
          default:   rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dual_chan_regdec.sv
module dual_chan_regdec
  import dual_chan_regdec_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CTR_W = 2 * DATA_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [3:0]                    bus_addr,
  input  logic                          bus_rd,
  input  logic                          bus_wr,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  input  logic [NUM_CH-1:0][DATA_W-1:0] stat_in,
  input  logic [NUM_CH-1:0][DATA_W-1:0] rxh_in,
  input  logic [DATA_W-1:0]             ipcr_in,
  input  logic [DATA_W-1:0]             isr_in,
  input  logic [CTR_W-1:0]              ctr_val_in,
  input  logic [DATA_W-2:0]             inport_in,
  output logic [NUM_CH-1:0][DATA_W-1:0] mode1_q,
  output logic [NUM_CH-1:0][DATA_W-1:0] mode2_q,
  output logic [NUM_CH-1:0][DATA_W-1:0] csel_q,
  output logic [NUM_CH-1:0]             ptr_at2,
  output logic [NUM_CH-1:0]             rx_en_q,
  output logic [NUM_CH-1:0]             tx_en_q,
  output logic [NUM_CH-1:0]             cmd_misc_stb,
  output logic [NUM_CH-1:0][2:0]        cmd_misc_code,
  output logic [NUM_CH-1:0]             tx_load,
  output logic [NUM_CH-1:0][DATA_W-1:0] tx_data,
  output logic [NUM_CH-1:0]             rx_pop,
  output logic [DATA_W-1:0]             aux_q,
  output logic [DATA_W-1:0]             imask_q,
  output logic [CTR_W-1:0]              preset_q,
  output logic [DATA_W-1:0]             opcfg_q,
  output logic                          op_set_stb,
  output logic                          op_clr_stb,
  output logic [DATA_W-1:0]             op_mask,
  output logic                          ctr_start,
  output logic                          ctr_stop
);
  // internal events brought out for the checker
  logic [NUM_CH-1:0]             ptr_adv;
  logic [NUM_CH-1:0]             ptr_rst;
  logic [NUM_CH-1:0][DATA_W-1:0] mode_sel;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dual_chan_regdec_chan #(.DATA_W(DATA_W), .CH_ID(g)) chan_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_rd     (bus_rd),
      .bus_wr     (bus_wr),
      .bus_wdata  (bus_wdata),
      .mode1_o    (mode1_q[g]),
      .mode2_o    (mode2_q[g]),
      .mode_sel_o (mode_sel[g]),
      .csel_o     (csel_q[g]),
      .ptr_o      (ptr_at2[g]),
      .rx_en_o    (rx_en_q[g]),
      .tx_en_o    (tx_en_q[g]),
      .misc_stb_o (cmd_misc_stb[g]),
      .misc_code_o(cmd_misc_code[g]),
      .tx_load_o  (tx_load[g]),
      .tx_data_o  (tx_data[g]),
      .rx_pop_o   (rx_pop[g]),
      .ptr_adv_o  (ptr_adv[g]),
      .ptr_rst_o  (ptr_rst[g])
    );
  end

  dual_chan_regdec_shared #(.DATA_W(DATA_W)) shared_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .aux_o      (aux_q),
    .imask_o    (imask_q),
    .preset_o   (preset_q),
    .opcfg_o    (opcfg_q),
    .op_mask_o  (op_mask),
    .op_set_o   (op_set_stb),
    .op_clr_o   (op_clr_stb),
    .ctr_start_o(ctr_start),
    .ctr_stop_o (ctr_stop)
  );

  dual_chan_regdec_rmux #(.DATA_W(DATA_W)) rmux_i (
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .mode_sel  (mode_sel),
    .stat_in   (stat_in),
    .rxh_in    (rxh_in),
    .ipcr_in   (ipcr_in),
    .isr_in    (isr_in),
    .ctr_val_in(ctr_val_in),
    .inport_in (inport_in),
    .rdata     (bus_rdata)
  );
endmodule

// File: rtl/dual_chan_regdec_chk.sv
module dual_chan_regdec_chk
  import dual_chan_regdec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [3:0]               bus_addr,
  input logic                     bus_rd,
  input logic                     bus_wr,
  input logic [DATA_W-1:0]        bus_wdata,
  input logic [DATA_W-1:0]        bus_rdata,
  input logic [NUM_CH-1:0]        ptr_at2,
  input logic [NUM_CH-1:0]        ptr_adv,
  input logic [NUM_CH-1:0]        ptr_rst,
  input logic [NUM_CH-1:0]        rx_en_q,
  input logic [NUM_CH-1:0]        cmd_misc_stb,
  input logic [NUM_CH-1:0]        tx_load,
  input logic [NUM_CH-1:0]        rx_pop,
  input logic                     op_set_stb,
  input logic                     op_clr_stb,
  input logic                     ctr_start,
  input logic                     ctr_stop
);
  // R9: counter strobes come only from reads of 14 / 15
  a_r9_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADR_CMD_A) |=> ctr_start);
  a_r9_stop_src: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_stop |-> $past(bus_rd && bus_addr == ADR_CMD_B));

  // R10: output-port strobes come only from writes of 14 / 15
  a_r10_set_src: assert property (@(posedge clk) disable iff (!rst_n)
    op_set_stb |-> $past(bus_wr && bus_addr == ADR_CMD_A));
  a_r10_clr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADR_CMD_B) |=> op_clr_stb);

  // R12: reserved reads return zero
  a_r12_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == ADR_RSVD || bus_addr == 4'd2 || bus_addr == 4'd10))
      |-> bus_rdata == '0);

  // R5 / R11: one access per cycle gives at most one strobe
  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_misc_stb, tx_load, rx_pop, op_set_stb, op_clr_stb, ctr_start, ctr_stop}));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R2: a mode access leaves the pointer at register 2
    a_r2_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_adv[g] |=> ptr_at2[g]);
    // R2: sticky until an explicit reset-pointer
    a_r2_ptr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_at2[g] && !ptr_rst[g]) |=> ptr_at2[g]);
    // R4: reset-pointer command returns it to register 1
    a_r4_ptr_reset: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_rst[g] |=> !ptr_at2[g]);
    // R6: receiver turns on only through an enable bit without disable
    a_r6_rx_on_src: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_en_q[g]) |-> $past(bus_wr && bus_wdata[0] && !bus_wdata[1]));
  end

  logic unused_ok;
  assign unused_ok = ^bus_wdata[DATA_W-1:2];
endmodule

bind dual_chan_regdec dual_chan_regdec_chk #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_rd      (bus_rd),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .ptr_at2     (ptr_at2),
  .ptr_adv     (ptr_adv),
  .ptr_rst     (ptr_rst),
  .rx_en_q     (rx_en_q),
  .cmd_misc_stb(cmd_misc_stb),
  .tx_load     (tx_load),
  .rx_pop      (rx_pop),
  .op_set_stb  (op_set_stb),
  .op_clr_stb  (op_clr_stb),
  .ctr_start   (ctr_start),
  .ctr_stop    (ctr_stop)
);

// File: tb/dual_chan_regdec_tb_top.sv
module dual_chan_regdec_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0][7:0] stat_in, rxh_in;
  logic [7:0] ipcr_in, isr_in;
  logic [15:0] ctr_val_in;
  logic [6:0] inport_in;
  logic [1:0][7:0] mode1_q, mode2_q, csel_q, tx_data;
  logic [1:0] ptr_at2, rx_en_q, tx_en_q, cmd_misc_stb, tx_load, rx_pop;
  logic [1:0][2:0] cmd_misc_code;
  logic [7:0] aux_q, imask_q, opcfg_q, op_mask;
  logic [15:0] preset_q;
  logic op_set_stb, op_clr_stb, ctr_start, ctr_stop;

  always #5 clk = ~clk;

  dual_chan_regdec dut_i (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  logic [7:0] m_m1[2], m_m2[2], m_cs[2], m_txd[2], m_aux, m_imr, m_opc, m_mask;
  logic [15:0] m_pre;
  logic [2:0] m_code[2];
  logic m_ptr[2], m_rx[2], m_tx[2], m_mstb[2], m_txl[2], m_rxp[2];
  logic m_set, m_clr, m_start, m_stop;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_m1[c] = 0; m_m2[c] = 0; m_cs[c] = 0; m_txd[c] = 0; m_code[c] = 0;
      m_ptr[c] = 0; m_rx[c] = 0; m_tx[c] = 0; m_mstb[c] = 0; m_txl[c] = 0; m_rxp[c] = 0;
    end
    m_aux = 0; m_imr = 0; m_opc = 0; m_mask = 0; m_pre = 0;
    m_set = 0; m_clr = 0; m_start = 0; m_stop = 0;
  endtask

  function automatic logic [7:0] model_read(logic [3:0] a);
    int c = a[3];
    if (!a[2]) begin
      case (a[1:0])
        2'd0: return m_ptr[c] ? m_m2[c] : m_m1[c];
        2'd1: return stat_in[c];
        2'd3: return rxh_in[c];
        default: return 8'h00;
      endcase
    end
    case (a)
      4'd4: return ipcr_in;
      4'd5: return isr_in;
      4'd6: return ctr_val_in[15:8];
      4'd7: return ctr_val_in[7:0];
      4'd13: return {1'b0, inport_in};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_step(logic rd, logic wr, logic [3:0] a, logic [7:0] d);
    int c = a[3];
    for (int k = 0; k < 2; k++) begin m_mstb[k] = 0; m_txl[k] = 0; m_rxp[k] = 0; end
    m_set = 0; m_clr = 0; m_start = 0; m_stop = 0;
    if (!(rd || wr)) return;
    if (!a[2]) begin
      case (a[1:0])
        2'd0: begin
          if (wr) begin if (m_ptr[c]) m_m2[c] = d; else m_m1[c] = d; end
          m_ptr[c] = 1;
        end
        2'd1: if (wr) m_cs[c] = d;
        2'd2: if (wr) begin
          if (d[1]) m_rx[c] = 0; else if (d[0]) m_rx[c] = 1;
          if (d[3]) m_tx[c] = 0; else if (d[2]) m_tx[c] = 1;
          if (d[6:4] != 0) begin m_mstb[c] = 1; m_code[c] = d[6:4]; end
          if (d[6:4] == 3'd1) m_ptr[c] = 0;
        end
        default: if (wr) begin m_txl[c] = 1; m_txd[c] = d; end else m_rxp[c] = 1;
      endcase
    end else begin
      case (a)
        4'd4: if (wr) m_aux = d;
        4'd5: if (wr) m_imr = d;
        4'd6: if (wr) m_pre[15:8] = d;
        4'd7: if (wr) m_pre[7:0] = d;
        4'd13: if (wr) m_opc = d;
        4'd14: if (wr) begin m_set = 1; m_mask = d; end else m_start = 1;
        4'd15: if (wr) begin m_clr = 1; m_mask = d; end else m_stop = 1;
        default: ;
      endcase
    end
  endtask

  task automatic compare_all();
    for (int c = 0; c < 2; c++) begin
      chk("R2 ptr", ptr_at2[c], m_ptr[c]);
      chk("R3 mode1", mode1_q[c], m_m1[c]);
      chk("R3 mode2", mode2_q[c], m_m2[c]);
      chk("R8 csel", csel_q[c], m_cs[c]);
      chk("R6 rx_en", rx_en_q[c], m_rx[c]);
      chk("R6 tx_en", tx_en_q[c], m_tx[c]);
      chk("R13 misc_stb", cmd_misc_stb[c], m_mstb[c]);
      chk("R13 misc_code", cmd_misc_code[c], m_code[c]);
      chk("R11 tx_load", tx_load[c], m_txl[c]);
      chk("R11 tx_data", tx_data[c], m_txd[c]);
      chk("R11 rx_pop", rx_pop[c], m_rxp[c]);
    end
    chk("R8 aux", aux_q, m_aux);
    chk("R8 imask", imask_q, m_imr);
    chk("R8 preset", preset_q, m_pre);
    chk("R8 opcfg", opcfg_q, m_opc);
    chk("R10 set", op_set_stb, m_set);
    chk("R10 clr", op_clr_stb, m_clr);
    chk("R10 mask", op_mask, m_mask);
    chk("R9 start", ctr_start, m_start);
    chk("R9 stop", ctr_stop, m_stop);
  endtask

  // one access, then an idle gap; called at a negedge
  task automatic step(logic rd, logic wr, logic [3:0] a, logic [7:0] d);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1;
    if (rd) chk((a == 2 || a == 10 || a == 12 || a > 13) ? "R12/R9 rdata" : "R7 rdata",
                bus_rdata, model_read(a));
    @(posedge clk);
    model_step(rd, wr, a, d);
    @(negedge clk);
    bus_rd = 0; bus_wr = 0;
    compare_all();
    @(posedge clk);
    model_step(0, 0, 0, 0);
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d); step(0, 1, a, d); endtask
  task automatic rd(logic [3:0] a); step(1, 0, a, 8'h00); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    stat_in = {8'hB1, 8'hA1}; rxh_in = {8'hB3, 8'hA3};
    ipcr_in = 8'h44; isr_in = 8'h55; ctr_val_in = 16'h6677; inport_in = 7'h5D;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk("R1 ptr in reset", ptr_at2, 2'b00);
    chk("R1 aux in reset", aux_q, 0);
    rst_n = 1;
    @(negedge clk);
    compare_all();
    chk("R1 strobes", {ctr_start, ctr_stop, op_set_stb, op_clr_stb, tx_load, rx_pop}, 0);

    // R2/R3 pointer walk on channel A
    wr(0, 8'h13);
    wr(0, 8'h27);
    rd(0);
    wr(0, 8'h55);
    chk("R3 mode2 A holds last", mode2_q[0], 8'h55);
    // R2 by read on channel B; R5 A untouched
    rd(8);
    chk("R5 A mode1 kept", mode1_q[0], 8'h13);
    // R4 non-reset code keeps pointer, reset code clears it
    wr(2, 8'h20);
    chk("R4 other code keeps ptr", ptr_at2[0], 1'b1);
    wr(2, 8'h10);
    chk("R4 reset-pointer clears A", ptr_at2[0], 1'b0);
    chk("R5 B ptr unaffected", ptr_at2[1], 1'b1);
    wr(0, 8'h66);
    // R6 enables
    wr(2, 8'h05);
    wr(10, 8'h04);
    wr(2, 8'h0A);
    wr(2, 8'h03);
    chk("R6 disable wins", rx_en_q[0], 1'b0);
    wr(10, 8'h00);
    // R8 shared and per-channel writes
    wr(4, 8'hC4); wr(5, 8'hC5); wr(6, 8'hC6); wr(7, 8'hC7);
    wr(13, 8'hCD); wr(1, 8'hCA); wr(9, 8'hCB);
    // R7/R12/R9 read of every address
    for (int a = 0; a < 16; a++) rd(4'(a));
    // R10 / R11
    wr(14, 8'h0F); wr(15, 8'hF0);
    wr(3, 8'h3A); wr(11, 8'h3B);
    // R12 reserved write changes nothing
    wr(12, 8'hFF);
    chk("R12 aux kept", aux_q, 8'hC4);
    chk("R12 opcfg kept", opcfg_q, 8'hCD);
    // new inputs, read again
    stat_in = {8'h19, 8'h91}; rxh_in = {8'h28, 8'h82}; ctr_val_in = 16'hBEEF;
    inport_in = 7'h7F;
    for (int a = 0; a < 16; a++) rd(4'(a));
    // R4 on channel B, then mode write lands in register 1
    wr(10, 8'h1C);
    wr(8, 8'h8E);
    chk("R4 B write into mode1", mode1_q[1], 8'h8E);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule